// File: doc/BRIEF.md
# Flash Erase Status Bit Generator

This block produces the status word that a NOR-style flash device returns on its 16-bit data bus while an embedded program or erase runs. Both byte lanes carry the same four status bits. The first is a device toggle that flips on every status read while an operation is active. The second is a sector toggle that flips only when the read address falls inside a sector marked for erase. The third is an exceeded-timing flag. The fourth is an erase-timer flag that tells software whether more sector erase commands are still accepted.

An external command decoder supplies the operation mode, the sector mask and a pulse-limit event. The block answers each status read combinationally from its own toggle, window and failure state. A reset command clears a failure. After a plain failure it returns the view to array read. After a failure in suspend-program mode it returns the view to erase-suspend read. The forced view lasts until the decoder changes the mode input.

Top module: `flash_status_gen`

## Requirements
- R1: After rst_n is released, with mode idle, the status word equals the array placeholder DATA_PH (default 16'hFFFF) and the failure flag is clear.
- R2: In a status word, only bits 6 (device toggle), 5 (exceeded timing), 3 (erase timer) and 2 (sector toggle) of each byte may be 1. The upper byte always equals the lower byte.
- R3: Mode codes are 0 idle, 1 program, 2 sector erase, 3 chip erase, 4 erase-suspend read and 5 suspend-program. Bit 6 inverts between successive reads (rd_stb high) in modes 1, 2, 3 and 5. It holds its value in every other mode.
- R4: The sector index is the top log2(NSEC) bits of rd_addr. In modes 2, 3, 4 and 5, bit 2 inverts between successive reads only if the read sector is selected. In every other mode it never inverts.
- R5: In mode 4, bit 2 still inverts on reads of selected sectors, and bit 6 does not.
- R6: In mode 4, a read of an unselected sector returns DATA_PH.
- R7: After entry into mode 2, bit 3 reads 0 for WIN_CYC clock edges. It reads 1 from edge WIN_CYC+1 onward and stays 1 while mode 2 holds.
- R8: While bit 3 is 0 in mode 2, a newly set sec_mask bit adds that sector and restarts the full window. After bit 3 is 1, new mask bits are ignored and those sectors do not toggle.
- R9: In mode 3, bit 3 reads 1 immediately and every sector counts as selected.
- R10: A limit_evt pulse in modes 1, 2, 3 or 5 sets bit 5 in both lanes, and bit 5 stays set until a reset command. The pulse is ignored in modes 0 and 4.
- R11: rst_cmd while failed clears bit 5. It then shows array read (DATA_PH), or erase-suspend read if the mode was 5, until the mode input changes. rst_cmd without a failure is ignored.
- R12: Modes 0, 6 and 7 return DATA_PH on every read, and no toggle moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | One-cycle pulse per status read cycle |
| rd_addr | input | AW | Read address |
| mode | input | 3 | Operation mode from the command decoder |
| sec_mask | input | NSEC | Sectors selected for erase |
| limit_evt | input | 1 | Internal pulse-count limit exceeded |
| rst_cmd | input | 1 | Reset command |
| dout | output | 16 | Status word or array placeholder |

## Verification
The bench builds the block with four sectors, a 4-bit address and a six-cycle erase window. With these values every sector mask combined with every sector can be swept, both in active sector erase and in erase-suspend read. The short window lets the bench count the expiry edge exactly. It also places a window restart and a post-expiry mask addition within a few dozen cycles. The failure and reset paths are driven from program, suspend-program, idle and suspend-read modes.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int NSEC = 8,
  parameter int AW = 20,
  parameter int WIN_CYC = 5000,
  parameter logic [15:0] DATA_PH = 16'hFFFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_stb,
  input  logic [AW-1:0]   rd_addr,
  input  logic [2:0]      mode,
  input  logic [NSEC-1:0] sec_mask,
  input  logic            limit_evt,
  input  logic            rst_cmd,
  output logic [15:0]     dout
);
  localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1;
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [AW-1:0] SEC_WORDS = AW'(2 ** (AW - SW));
  localparam logic [2:0] M_IDLE = 3'd0, M_PROG = 3'd1, M_SERA = 3'd2,
                         M_CERA = 3'd3, M_SUSP = 3'd4, M_SPRG = 3'd5;

  logic [2:0]      cur, force_mode, held;
  logic            force_en, fail_q, armed, tog_dev, tog_sec;
  logic [NSEC-1:0] sel_q, sel_eff;
  logic [CW-1:0]   win;
  logic [SW-1:0]   sec_idx;
  logic            busy, erase_ctx, sec_hit, show, timer_on, mask_new;
  logic [7:0]      lane;

  assign cur       = force_en ? force_mode : mode;
  assign busy      = (cur == M_PROG) || (cur == M_SERA) || (cur == M_CERA) || (cur == M_SPRG);
  assign erase_ctx = (cur == M_SERA) || (cur == M_CERA) || (cur == M_SUSP) || (cur == M_SPRG);
  assign sec_idx   = SW'(rd_addr / SEC_WORDS);
  assign sel_eff   = armed ? sel_q : sec_mask;
  assign sec_hit   = (cur == M_CERA) || sel_eff[sec_idx];
  assign mask_new  = |(sec_mask & ~sel_q);
  assign timer_on  = (cur == M_CERA) || (cur == M_SERA && armed && win == '0);
  assign show      = busy || (cur == M_SUSP && sec_hit);
  assign lane      = {1'b0, tog_dev, fail_q, 1'b0, timer_on, tog_sec, 2'b00};
  assign dout      = show ? {lane, lane} : DATA_PH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_dev <= 1'b0;
      tog_sec <= 1'b0;
    end else if (rd_stb) begin
      if (busy) tog_dev <= ~tog_dev;
      if (erase_ctx && sec_hit) tog_sec <= ~tog_sec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      sel_q <= '0;
      win   <= '0;
    end else if (cur == M_SERA) begin
      if (!armed) begin
        armed <= 1'b1;
        sel_q <= sec_mask;
        win   <= CW'(WIN_CYC);
      end else if (win != '0) begin
        if (mask_new) begin
          sel_q <= sel_q | sec_mask;
          win   <= CW'(WIN_CYC);
        end else begin
          win <= win - CW'(1);
        end
      end
    end else if (!erase_ctx) begin
      armed <= 1'b0;
      sel_q <= '0;
      win   <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q     <= 1'b0;
      force_en   <= 1'b0;
      force_mode <= M_IDLE;
      held       <= M_IDLE;
    end else begin
      if (force_en && mode != held) force_en <= 1'b0;
      if (rst_cmd && fail_q) begin
        fail_q     <= 1'b0;
        force_en   <= 1'b1;
        force_mode <= (cur == M_SPRG) ? M_SUSP : M_IDLE;
        held       <= mode;
      end else if (limit_evt && busy) begin
        fail_q <= 1'b1;
      end
    end
  end
endmodule

module flash_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_stb,
  input logic        limit_evt,
  input logic        rst_cmd,
  input logic [2:0]  cur,
  input logic        tog_dev,
  input logic        tog_sec,
  input logic        sec_hit,
  input logic        fail_q,
  input logic        timer_on,
  input logic [15:0] dout
);
  logic busy_c, togctx_c;
  assign busy_c   = (cur == 3'd1) || (cur == 3'd2) || (cur == 3'd3) || (cur == 3'd5);
  assign togctx_c = (cur >= 3'd2) && (cur <= 3'd5);

  // R2
  lanes_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout[7:0] == dout[15:8]);

  // R3
  dev_tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_c |=> $stable(tog_dev));

  // R4
  sec_tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && togctx_c && sec_hit) |=> $stable(tog_sec));

  // R7
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == 3'd2 && timer_on) |=> (timer_on || cur != 3'd2));

  // R10
  fail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_evt && busy_c && !rst_cmd) |=> fail_q);

  // R11
  fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cmd && fail_q) |=> !fail_q);
endmodule

bind flash_status_gen flash_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .limit_evt(limit_evt),
  .rst_cmd(rst_cmd), .cur(cur), .tog_dev(tog_dev), .tog_sec(tog_sec),
  .sec_hit(sec_hit), .fail_q(fail_q), .timer_on(timer_on), .dout(dout)
);

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;
  localparam int W = 6;
  localparam logic [15:0] PH = 16'hFFFF;

  logic clk = 1'b0, rst_n = 1'b0, rd_stb = 1'b0, limit_evt = 1'b0, rst_cmd = 1'b0;
  logic [3:0] rd_addr = '0, sec_mask = '0;
  logic [2:0] mode = '0;
  logic [15:0] dout, a, b;
  int total = 0, fails = 0;

  flash_status_gen #(.NSEC(4), .AW(4), .WIN_CYC(W)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr), .mode(mode),
    .sec_mask(sec_mask), .limit_evt(limit_evt), .rst_cmd(rst_cmd), .dout(dout));

  always #5 clk = ~clk;

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] ad, output logic [15:0] v);
    @(negedge clk);
    rd_addr = ad; rd_stb = 1'b1;
    #1 v = dout;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic setm(input logic [2:0] m, input logic [3:0] k);
    @(negedge clk);
    mode = m; sec_mask = k;
  endtask

  task automatic pulse_lim();
    @(negedge clk); limit_evt = 1'b1;
    @(negedge clk); limit_evt = 1'b0;
  endtask

  task automatic pulse_rst();
    @(negedge clk); rst_cmd = 1'b1;
    @(negedge clk); rst_cmd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 reset", dout, PH);
    rd(4'h0, a); rd(4'h0, b);
    chk("R12 idle reads", a & b, PH);
    setm(3'd7, 4'hF);
    rd(4'h4, a); rd(4'h4, b);
    chk("R12 unused mode", a & b, PH);

    setm(3'd1, 4'hF);
    rd(4'h0, a); rd(4'h0, b);
    chk("R3 program toggle", (a ^ b) & 16'h4444, 16'h4040);
    chk("R2 bit layout", {a[15:8] ^ a[7:0], a[7:0] & 8'h93}, 16'h0000);

    for (int m = 0; m < 16; m++) begin
      setm(3'd0, 4'h0);
      setm(3'd2, 4'(m));
      for (int s = 0; s < 4; s++) begin
        rd(4'(s << 2), a); rd(4'(s << 2), b);
        chk("R4 erase sweep", (a ^ b) & 16'h4444, m[s] ? 16'h4444 : 16'h4040);
      end
      setm(3'd4, 4'(m));
      for (int s = 0; s < 4; s++) begin
        rd(4'(s << 2), a); rd(4'(s << 2), b);
        if (m[s]) chk("R5 suspend toggle", (a ^ b) & 16'h4444, 16'h0404);
        else      chk("R6 suspend unselected", a & b, PH);
      end
    end

    setm(3'd0, 4'h0);
    setm(3'd2, 4'h1);
    repeat (W) @(negedge clk);
    #1 chk("R7 window open", dout & 16'h0808, 16'h0000);
    @(negedge clk);
    #1 chk("R7 window closed", dout & 16'h0808, 16'h0808);
    repeat (W) @(negedge clk);
    #1 chk("R7 stays set", dout & 16'h0808, 16'h0808);

    setm(3'd0, 4'h0);
    setm(3'd2, 4'h1);
    repeat (3) @(negedge clk);
    sec_mask = 4'h3;
    repeat (W) @(negedge clk);
    #1 chk("R8 restarted window", dout & 16'h0808, 16'h0000);
    @(negedge clk);
    #1 chk("R8 restarted expiry", dout & 16'h0808, 16'h0808);
    sec_mask = 4'h7;
    rd(4'h8, a); rd(4'h8, b);
    chk("R8 late add ignored", (a ^ b) & 16'h0404, 16'h0000);
    rd(4'h4, a); rd(4'h4, b);
    chk("R8 added sector toggles", (a ^ b) & 16'h0404, 16'h0404);

    setm(3'd0, 4'h0);
    setm(3'd3, 4'h0);
    #1 chk("R9 chip timer", dout & 16'h0808, 16'h0808);
    for (int s = 0; s < 4; s++) begin
      rd(4'(s << 2), a); rd(4'(s << 2), b);
      chk("R9 chip all sectors", (a ^ b) & 16'h0404, 16'h0404);
    end

    setm(3'd0, 4'h0);
    pulse_lim();
    setm(3'd1, 4'h0);
    rd(4'h0, a);
    chk("R10 idle limit ignored", a & 16'h2020, 16'h0000);
    pulse_rst();
    rd(4'h0, a);
    chk("R11 reset ignored", {15'd0, a == PH}, 16'h0000);
    pulse_lim();
    rd(4'h0, a); rd(4'h0, b);
    chk("R10 fail set", a & b & 16'h2020, 16'h2020);
    pulse_rst();
    rd(4'h0, a); rd(4'h0, b);
    chk("R11 back to array", a & b, PH);
    setm(3'd0, 4'h0);
    setm(3'd1, 4'h0);
    rd(4'h0, a);
    chk("R11 fail cleared", a & 16'h2020, 16'h0000);

    setm(3'd0, 4'h0);
    setm(3'd2, 4'h2);
    setm(3'd4, 4'h2);
    pulse_lim();
    rd(4'h4, a);
    chk("R10 suspend limit ignored", a & 16'h2020, 16'h0000);
    setm(3'd5, 4'h2);
    pulse_lim();
    rd(4'h4, a);
    chk("R10 suspend-program fail", a & 16'h2020, 16'h2020);
    pulse_rst();
    rd(4'h4, a); rd(4'h4, b);
    chk("R11 to suspend read", {(a ^ b) & 16'h4444} | (a & 16'h2020), 16'h0404);
    rd(4'h0, a);
    chk("R11 suspend unselected", a, PH);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule